// File: doc/BRIEF.md
# Gated-Clock Parallel/Serial Shift Register

This block is a register of `WIDTH` stages (eight by default) that is filled either all at once from a parallel word or one bit at a time from a serial input. Only the final stage leaves the block as a serial bit stream. It is used to serialise a captured word, to delay a serial stream by `WIDTH` clocks, or to mix the two.

The block runs on one free-running system clock. A clock-inhibit input is sampled on each rising edge and acts as a synchronous enable. While it is high, every stage holds its value. While it is low, the mode input chooses between a parallel load and a one-place shift toward the output. An active-low clear works asynchronously, outranks every other input and empties the register. The clear also serves as the block's reset.

A debug output shows all stages, so that a bench or a debug probe can follow the whole word.

Top module: `psr_shift_reg`

## Requirements
- R1: While `clr_n` is low, every stage reads 0 at each rising clock edge, whatever the other inputs are.
- R2: A falling `clr_n` zeroes all stages at once, without waiting for a clock edge.
- R3: When `clk_inh` is high at a rising edge, no stage changes, whatever `shift_nload`, `ser_in` and `par_in` are.
- R4: When `clk_inh` is low and `shift_nload` is 0 at a rising edge, stage i takes `par_in[i]` for every i. Stage 0 is the first stage and stage WIDTH-1 is the last.
- R5: During a parallel load the value of `ser_in` has no effect on any stage.
- R6: When `clk_inh` is low and `shift_nload` is 1 at a rising edge, stage 0 takes `ser_in` and stage i takes the old value of stage i-1.
- R7: `ser_out` is the last stage. After a load edge, `ser_out` equals `par_in[WIDTH-1]`. After k further shift edges it equals the loaded `par_in[WIDTH-1-k]`.
- R8: A bit presented on `ser_in` at a shift edge appears on `ser_out` after exactly WIDTH shift edges.
- R9: `clk_inh` acts only through its value at the rising edge. Pulses on it between edges have no effect.
- R10: `stages_dbg[i]` shows stage i after every edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock, rising edge active |
| clr_n | input | 1 | Asynchronous active-low clear, overrides all |
| clk_inh | input | 1 | Clock inhibit, high freezes all stages |
| shift_nload | input | 1 | 1 = shift toward output, 0 = parallel load |
| ser_in | input | 1 | Serial data entering stage 0 |
| par_in | input | WIDTH | Parallel word, bit i goes to stage i |
| ser_out | output | 1 | Last stage |
| stages_dbg | output | WIDTH | All stages, bit i is stage i |

## Verification
Two pairs of functions can act in the same cycle. The first pair is clear and a clock edge: the bench pulls `clr_n` low while the inputs request a load or a shift, and keeps it low across the edge. It then expects zeros both immediately and after the edge. The second pair is inhibit and a mode request. Here the bench holds `clk_inh` high with random mode and data, and also pulses `clk_inh` between edges. The scoreboard model decides from the edge value alone whether the word holds, loads or shifts, and every stage is compared after each edge.

// File: rtl/psr_pkg.sv
// Package: shared types for the parallel/serial shift register.
// Assumes: nothing beyond IEEE 1800-2017.
package psr_pkg;

    // Per-edge action applied to every stage.
    typedef enum logic [1:0] {
        PSR_HOLD  = 2'd0,
        PSR_LOAD  = 2'd1,
        PSR_SHIFT = 2'd2
    } psr_op_e;

endpackage

// File: rtl/psr_ctrl.sv
// Module: psr_ctrl
// Decodes the inhibit and mode inputs into one action per edge.
// Assumes: inputs are synchronous to the register clock; inhibit wins over mode.
module psr_ctrl
    import psr_pkg::*;
(
    input  logic    clk_inh,
    input  logic    shift_nload,
    output psr_op_e op
);

    // Purpose: select hold, load or shift for the coming edge.
    always_comb begin
        if (clk_inh) begin
            op = PSR_HOLD;
        end else if (shift_nload) begin
            op = PSR_SHIFT;
        end else begin
            op = PSR_LOAD;
        end
    end

endmodule

// File: rtl/psr_stage.sv
// Module: psr_stage
// One storage bit: holds, loads its parallel bit or takes its shift source.
// Assumes: clr_n is asynchronous and active low; op is stable at the edge.
module psr_stage
    import psr_pkg::*;
(
    input  logic    clk,
    input  logic    clr_n,
    input  psr_op_e op,
    input  logic    load_bit,
    input  logic    shift_bit,
    output logic    q
);

    // Purpose: update the bit on the rising edge, clear it at once on clr_n.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            q <= 1'b0;
        end else begin
            case (op)
                PSR_LOAD:  q <= load_bit;
                PSR_SHIFT: q <= shift_bit;
                default:   q <= q;
            endcase
        end
    end

endmodule

// File: rtl/psr_shift_reg.sv
// Module: psr_shift_reg (top)
// WIDTH-stage register, loaded in parallel or serially. Only the last stage
// is the output. The inhibit input is a synchronous clock enable.
// Assumes: one free-running clock; clr_n released away from a clock edge.
module psr_shift_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             clk_inh,
    input  logic             shift_nload,
    input  logic             ser_in,
    input  logic [WIDTH-1:0] par_in,
    output logic             ser_out,
    output logic [WIDTH-1:0] stages_dbg
);
    import psr_pkg::*;

    localparam int LAST = WIDTH - 1;

    psr_op_e          op;
    logic [WIDTH-1:0] q;
    logic [WIDTH-1:0] shift_src;

    psr_ctrl u_ctrl (
        .clk_inh     (clk_inh),
        .shift_nload (shift_nload),
        .op          (op)
    );

    // One stage per bit. Stage 0 is fed from ser_in, the others from their neighbour.
    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        if (i == 0) begin : g_head
            assign shift_src[i] = ser_in;
        end else begin : g_body
            assign shift_src[i] = q[i-1];
        end

        psr_stage u_stage (
            .clk       (clk),
            .clr_n     (clr_n),
            .op        (op),
            .load_bit  (par_in[i]),
            .shift_bit (shift_src[i]),
            .q         (q[i])
        );
    end

    assign ser_out    = q[LAST];
    assign stages_dbg = q;

endmodule

// File: rtl/psr_shift_reg_chk.sv
// Module: psr_shift_reg_chk
// Checker bound to psr_shift_reg. It relates the edge inputs to the stages
// on the following cycle.
// Assumes: clr_n low across at least one rising edge whenever it is pulsed.
module psr_shift_reg_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             clr_n,
    input logic             clk_inh,
    input logic             shift_nload,
    input logic             ser_in,
    input logic [WIDTH-1:0] par_in,
    input logic             ser_out,
    input logic [WIDTH-1:0] stages_dbg
);

    // Purpose: R1, the register reads zero whenever clear is held at an edge.
    always @(posedge clk) begin
        if (!clr_n) begin
            p_clear_zero_r1: assert (stages_dbg == '0);
        end
    end

    // R3: inhibit freezes every stage.
    p_inhibit_hold_r3: assert property (@(posedge clk) disable iff (!clr_n)
        clk_inh |=> $stable(stages_dbg));

    // R4: parallel load copies the word.
    p_load_word_r4: assert property (@(posedge clk) disable iff (!clr_n)
        (!clk_inh && !shift_nload) |=> stages_dbg == $past(par_in));

    // R6: a shift moves each bit one stage on and takes ser_in into stage 0.
    p_shift_move_r6: assert property (@(posedge clk) disable iff (!clr_n)
        (!clk_inh && shift_nload) |=>
            stages_dbg == {$past(stages_dbg[WIDTH-2:0]), $past(ser_in)});

    // R7: after a load, the output shows the top parallel bit.
    p_load_out_r7: assert property (@(posedge clk) disable iff (!clr_n)
        (!clk_inh && !shift_nload) |=> ser_out == $past(par_in[WIDTH-1]));

endmodule

bind psr_shift_reg psr_shift_reg_chk #(.WIDTH(WIDTH)) u_chk (
    .clk         (clk),
    .clr_n       (clr_n),
    .clk_inh     (clk_inh),
    .shift_nload (shift_nload),
    .ser_in      (ser_in),
    .par_in      (par_in),
    .ser_out     (ser_out),
    .stages_dbg  (stages_dbg)
);

// File: tb/psr_shift_reg_tb.sv
// Scoreboard bench: driver tasks push the expected word per edge, a monitor
// pops and compares it after each rising edge.
module psr_shift_reg_tb;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         clr_n = 1'b1;
    logic         clk_inh = 1'b0;
    logic         shift_nload = 1'b0;
    logic         ser_in = 1'b0;
    logic [W-1:0] par_in = '0;
    logic         ser_out;
    logic [W-1:0] stages_dbg;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [W-1:0] exp;
        string        tag;
    } item_t;

    item_t        sb[$];
    logic [W-1:0] model = '0;

    always #4 clk = ~clk;

    psr_shift_reg #(.WIDTH(W)) u_dut (
        .clk         (clk),
        .clr_n       (clr_n),
        .clk_inh     (clk_inh),
        .shift_nload (shift_nload),
        .ser_in      (ser_in),
        .par_in      (par_in),
        .ser_out     (ser_out),
        .stages_dbg  (stages_dbg)
    );

    task automatic compare(input logic [W-1:0] exp, input string tag);
        checks++;
        if (stages_dbg !== exp || ser_out !== exp[W-1]) begin
            errors++;
            $display("FAIL %s stages=%h ser_out=%b expected stages=%h ser_out=%b",
                     tag, stages_dbg, ser_out, exp, exp[W-1]);
        end
    endtask

    // One cycle: drive at the falling edge, predict the rising edge.
    task automatic step(input logic inh, input logic sl, input logic ser,
                        input logic [W-1:0] par, input string tag, input bit glitch);
        item_t it;
        @(negedge clk);
        clr_n       = 1'b1;
        shift_nload = sl;
        ser_in      = ser;
        par_in      = par;
        clk_inh     = glitch ? ~inh : inh;
        if (glitch) begin
            #1 clk_inh = inh;
        end
        if (!inh) begin
            model = sl ? {model[W-2:0], ser} : par;
        end
        it.exp = model;
        it.tag = tag;
        sb.push_back(it);
    endtask

    // Clear in the middle of traffic: check at once (R2), then across an edge (R1).
    task automatic do_clear();
        item_t it;
        @(negedge clk);
        clk_inh     = 1'b0;
        shift_nload = $urandom_range(0, 1);
        ser_in      = 1'b1;
        par_in      = W'($urandom);
        clr_n       = 1'b0;
        #1 compare('0, "R2 async clear");
        model  = '0;
        it.exp = '0;
        it.tag = "R1 clear over edge";
        sb.push_back(it);
    endtask

    // Monitor: compare one expected item after each rising edge.
    initial begin
        item_t it;
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                it = sb.pop_front();
                compare(it.exp, it.tag);
            end
        end
    end

    // Watchdog.
    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #1 clr_n = 1'b0;
        #1 compare('0, "R1 reset state");
        @(negedge clk);
        model = '0;

        // R4 / R10: load a word, every stage checked.
        step(0, 0, 0, 8'hA5, "R4 load A5", 0);
        // R7: shift the word out, the top bit first.
        for (int k = 0; k < W; k++) step(0, 1, 0, 8'h00, "R7 shift out", 0);
        // R5: loads with ser_in at 1 and 0 give the same word.
        step(0, 0, 1, 8'h3C, "R5 load ser=1", 0);
        step(0, 0, 0, 8'hC3, "R5 load ser=0", 0);
        step(0, 0, 1, 8'hC3, "R5 load ser=1 again", 0);
        // R3: inhibit holds against every mode and data.
        step(1, 0, 1, 8'hFF, "R3 inhibit vs load", 0);
        step(1, 1, 1, 8'h00, "R3 inhibit vs shift", 0);
        step(1, 1, 0, 8'h5A, "R3 inhibit vs shift 0", 0);
        // R9: a pulse between edges has no effect in either direction.
        step(0, 1, 1, 8'h00, "R9 inh pulse high then low", 1);
        step(1, 0, 0, 8'hFF, "R9 inh pulse low then high", 1);
        // R8: one marked bit travels through all W stages.
        step(0, 0, 0, 8'h00, "R8 zero fill", 0);
        step(0, 1, 1, 8'h00, "R8 inject", 0);
        for (int k = 0; k < W - 1; k++) step(0, 1, 0, 8'h00, "R8 travel", 0);
        // R6 / R10: random shifts and loads with clears in between.
        for (int n = 0; n < 400; n++) begin
            if ($urandom_range(0, 24) == 0) begin
                do_clear();
            end else begin
                step(($urandom_range(0, 3) == 0), ($urandom_range(0, 3) != 0),
                     1'($urandom), W'($urandom), "R6 R10 random", $urandom_range(0, 7) == 0);
            end
        end
        repeat (3) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule